// File: doc/BRIEF.md
# Serial Codec Register Access Master

This block lets a processor read and write the sixteen 16-bit control registers of an external codec over a framed serial link. The processor sees a single 21-bit command/status word on a simple synchronous bus port. The word it writes is a command: a 4-bit codec register address, a write flag and 16 bits of write data. The word it reads back is the result of the most recent completed codec operation.

The block generates the bit clock and a one-bit-wide frame sync. At each frame start it copies the current command into a transmit shifter. It sends the command in the control part of the frame (subframe 0) and captures the 16 data bits the codec returns. After subframe 0 ends it stores the returned address and data, with the write flag cleared, into the status word. The same command is sent again in every frame until the processor writes a new one, so one write to the port produces a continuous series of codec accesses. The codec returns the addressed register on every access. A write access therefore also reads the register: the frame that performs the write returns the old contents, and the next frame returns the new contents.

Top module: `codec_cmd_master`

## Requirements
- R1: The bus word is laid out as address in bits [20:17], write flag in bit [16] (1 = write, 0 = read) and data in bits [15:0]. Bits [31:21] of a bus write are ignored, and they always read as zero.
- R2: A command written on the bus is copied into the transmit shifter at the next frame start, which is the rise of frame_sync. A bus write in the middle of a frame does not change what that frame sends or returns.
- R3: A frame is 128 bit periods long and a bit period is BIT_DIV clocks. bit_clk is high for the first half of each bit period. frame_sync is high for exactly one bit period, at bit position 0.
- R4: In each frame, ser_out carries the address MSB first in bit positions 36 to 39, the write flag in position 40 and the data MSB first in positions 41 to 56. ser_out is zero in every other position. Data is sent even for reads.
- R5: ser_in is sampled at the falling edge of bit_clk in positions 41 to 56, MSB first. After position 64 the status word is loaded with the frame's address, a write flag of 0 and the sampled data. The status word changes at no other time.
- R6: For a write command, the status after that frame holds the register's previous value. The status after the following frame holds the written value.
- R7: The stored command is performed in every frame until it is overwritten, so the status follows any change of the codec register.
- R8: After reset the status word reads as zero and the stored command is a read of address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 32 | Bus write data (command) |
| rd_data | output | 32 | Bus read data (status of the last completed operation) |
| bit_clk | output | 1 | Serial bit clock |
| frame_sync | output | 1 | Frame sync, high for bit position 0 |
| ser_out | output | 1 | Serial data to the codec |
| ser_in | input | 1 | Serial data from the codec |

## Verification
A behavioural codec model in the bench decodes ser_out and answers on ser_in. A write sweep covers all sixteen addresses with distinct data. It separates the old value returned in the frame that performs the write from the new value returned in the next frame, and it exposes address or bit-order mistakes. A read sweep sends a data pattern that must not be written. The model then changes each register behind the block's back, which shows that the command is repeated every frame. A command change in mid-frame checks that the frame in progress is not affected. A write with bits [31:21] set checks that those bits are dropped and that the returned write flag is cleared.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 16;
   localparam int CMD_W  = ADDR_W + 1 + DATA_W;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic              wr;
      logic [DATA_W-1:0] data;
   } cmd_t;
endpackage

// File: rtl/ccm_frame_timer.sv
module ccm_frame_timer #(
   parameter int BIT_DIV    = 4,
   parameter int FRAME_BITS = 128,
   localparam int POS_W     = $clog2(FRAME_BITS),
   localparam int HALF      = BIT_DIV / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             bit_clk,
   output logic             sync,
   output logic             bit_mid,
   output logic             bit_end,
   output logic             frame_load,
   output logic [POS_W-1:0] pos
);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

   generate
      if (BIT_DIV == 2) begin : g_div2
         logic phase;
         always_ff @(posedge clk) begin
            if (!rst_n) phase <= 1'b0;
            else        phase <= ~phase;
         end
         assign bit_clk = ~phase;
         assign bit_mid = ~phase;
         assign bit_end = phase;
      end else begin : g_divn
         localparam int PH_W = $clog2(BIT_DIV);
         logic [PH_W-1:0] phase;
         always_ff @(posedge clk) begin
            if (!rst_n)                             phase <= '0;
            else if (phase == PH_W'(BIT_DIV - 1))   phase <= '0;
            else                                    phase <= phase + 1'b1;
         end
         assign bit_clk = (phase < PH_W'(HALF));
         assign bit_mid = (phase == PH_W'(HALF - 1));
         assign bit_end = (phase == PH_W'(BIT_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          pos <= '0;
      else if (bit_end)    pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
   end

   assign sync       = (pos == '0);
   assign frame_load = bit_end && (pos == LAST_POS);

   a_r3_sync_on_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync) |-> $past(bit_end));
   a_r3_pos_moves_on_bit_end: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_end |=> $stable(pos));
endmodule

// File: rtl/ccm_tx_shift.sv
module ccm_tx_shift
   import ccm_pkg::*;
#(
   parameter int POS_W    = 7,
   parameter int ADDR_POS = 36,
   localparam int LAST_TX = ADDR_POS + CMD_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  cmd_t              cmd_in,
   input  logic              bit_end,
   input  logic [POS_W-1:0]  pos,
   output logic              dout,
   output logic [ADDR_W-1:0] addr_q
);
   logic [CMD_W-1:0] sh_q;
   logic             in_field;

   assign in_field = (pos >= POS_W'(ADDR_POS)) && (pos <= POS_W'(LAST_TX));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         addr_q <= '0;
      end else if (load) begin
         sh_q   <= cmd_in;
         addr_q <= cmd_in.addr;
      end else if (bit_end && in_field) begin
         sh_q   <= {sh_q[CMD_W-2:0], 1'b0};
      end
   end

   assign dout = in_field & sh_q[CMD_W-1];

   a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(addr_q));
   a_r4_shift_only_in_field: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !in_field) |=> $stable(sh_q));
endmodule

// File: rtl/ccm_rx_capture.sv
module ccm_rx_capture #(
   parameter int POS_W     = 7,
   parameter int DATA_POS  = 41,
   parameter int DATA_W    = 16,
   localparam int LAST_RX  = DATA_POS + DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_mid,
   input  logic [POS_W-1:0]  pos,
   input  logic              din,
   output logic [DATA_W-1:0] data_q
);
   logic in_field;

   assign in_field = (pos >= POS_W'(DATA_POS)) && (pos <= POS_W'(LAST_RX));

   always_ff @(posedge clk) begin
      if (!rst_n)                   data_q <= '0;
      else if (bit_mid && in_field) data_q <= {data_q[DATA_W-2:0], din};
   end

   a_r5_rx_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
      !in_field |=> $stable(data_q));
endmodule

// File: rtl/codec_cmd_master.sv
module codec_cmd_master
   import ccm_pkg::*;
#(
   parameter int BIT_DIV    = 4,
   parameter int FRAME_BITS = 128,
   parameter int SUB0_BITS  = 64,
   parameter int ADDR_POS   = 36,
   parameter int BUS_W      = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [BUS_W-1:0] wr_data,
   output logic [BUS_W-1:0] rd_data,
   output logic             bit_clk,
   output logic             frame_sync,
   output logic             ser_out,
   input  logic             ser_in
);
   localparam int POS_W    = $clog2(FRAME_BITS);
   localparam int DATA_POS = ADDR_POS + ADDR_W + 1;
   localparam int LAST_BIT = DATA_POS + DATA_W - 1;

   generate
      if (BIT_DIV < 2 || (BIT_DIV % 2) != 0) begin : g_bad_div
         $error("BIT_DIV must be even and at least 2");
      end
      if (LAST_BIT >= SUB0_BITS || SUB0_BITS >= FRAME_BITS) begin : g_bad_frame
         $error("command field must end inside subframe 0, subframe 0 inside the frame");
      end
      if (BUS_W < CMD_W) begin : g_bad_bus
         $error("bus must hold the command word");
      end
   endgenerate

   logic              bit_mid, bit_end, frame_load, update;
   logic [POS_W-1:0]  pos;
   logic [ADDR_W-1:0] tx_addr;
   logic [DATA_W-1:0] rx_data;
   cmd_t              cmd_q, stat_q;

   ccm_frame_timer #(.BIT_DIV(BIT_DIV), .FRAME_BITS(FRAME_BITS)) u_timer (
      .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .sync(frame_sync),
      .bit_mid(bit_mid), .bit_end(bit_end), .frame_load(frame_load), .pos(pos));

   ccm_tx_shift #(.POS_W(POS_W), .ADDR_POS(ADDR_POS)) u_tx (
      .clk(clk), .rst_n(rst_n), .load(frame_load), .cmd_in(cmd_q),
      .bit_end(bit_end), .pos(pos), .dout(ser_out), .addr_q(tx_addr));

   ccm_rx_capture #(.POS_W(POS_W), .DATA_POS(DATA_POS), .DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .bit_mid(bit_mid), .pos(pos),
      .din(ser_in), .data_q(rx_data));

   assign update = bit_end && (pos == POS_W'(SUB0_BITS));

   always_ff @(posedge clk) begin
      if (!rst_n)     cmd_q <= '0;
      else if (wr_en) cmd_q <= wr_data[CMD_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      stat_q <= '0;
      else if (update) stat_q <= '{addr: tx_addr, wr: 1'b0, data: rx_data};
   end

   assign rd_data = {{(BUS_W-CMD_W){1'b0}}, stat_q};

   a_r1_cmd_taken: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cmd_q == $past(wr_data[CMD_W-1:0]));
   a_r7_cmd_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cmd_q));
   a_r5_status_only_after_sub0: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stat_q) |-> $past(update));
   a_r5_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      update |=> !stat_q.wr);
endmodule

// File: tb/codec_cmd_master_bench.sv
module codec_cmd_master_bench;
   localparam int DIV   = 4;
   localparam int FRAME = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        bit_clk, frame_sync, ser_out;
   logic        ser_in = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   codec_cmd_master #(.BIT_DIV(DIV)) u_codec_cmd_master (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .bit_clk(bit_clk), .frame_sync(frame_sync), .ser_out(ser_out), .ser_in(ser_in));

   // behavioural codec
   logic [15:0] creg [16];
   int          p = 0;
   logic [3:0]  c_addr;
   logic        c_rw;
   logic [15:0] c_data;
   logic [3:0]  seen_addr;
   logic        seen_rw;
   logic [15:0] seen_data;
   int          stray_ones = 0;

   function automatic logic [15:0] init_val(int i);
      return 16'(i * 16'h1357) ^ 16'h00A5;
   endfunction

   function automatic logic [15:0] new_val(int i);
      return 16'(i * 16'h0F31) ^ 16'hC35A;
   endfunction

   initial for (int i = 0; i < 16; i++) creg[i] = init_val(i);

   always @(negedge bit_clk) begin
      if (frame_sync) p = 0;
      else            p = p + 1;
      if (p >= 36 && p <= 39)      c_addr = {c_addr[2:0], ser_out};
      else if (p == 40)            c_rw   = ser_out;
      else if (p >= 41 && p <= 56) c_data = {c_data[14:0], ser_out};
      else if (ser_out)            stray_ones = stray_ones + 1;
      if (p == 64) begin
         if (c_rw) creg[c_addr] = c_data;
         seen_addr = c_addr;
         seen_rw   = c_rw;
         seen_data = c_data;
      end
      if (p + 1 >= 41 && p + 1 <= 56) ser_in <= creg[c_addr][56 - (p + 1)];
      else                            ser_in <= 1'b0;
   end

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [31:0] v);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = '0;
   endtask

   task automatic next_frame();
      @(posedge frame_sync);
      @(negedge clk);
   endtask

   function automatic logic [31:0] stat(input logic [3:0] a, input logic [15:0] d);
      return {11'b0, a, 1'b0, d};
   endfunction

   initial begin
      repeat (int'(200000) - 10000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] cur [16];
      int hi, lo, bh;
      for (int i = 0; i < 16; i++) cur[i] = init_val(i);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: reset state
      chk(rd_data == 32'h0, "R8 status after reset", rd_data, 32'h0);

      // R3: framing and bit clock widths
      while (frame_sync) @(negedge clk);
      while (!frame_sync) @(negedge clk);
      hi = 0;
      while (frame_sync) begin hi++; @(negedge clk); end
      lo = 0;
      while (!frame_sync) begin lo++; @(negedge clk); end
      chk(hi == DIV, "R3 sync width", hi, DIV);
      chk(hi + lo == FRAME * DIV, "R3 frame length", hi + lo, FRAME * DIV);
      while (bit_clk) @(negedge clk);
      while (!bit_clk) @(negedge clk);
      bh = 0;
      while (bit_clk) begin bh++; @(negedge clk); end
      chk(bh == DIV / 2, "R3 bit clock high time", bh, DIV / 2);

      // R6 write sweep over all addresses
      for (int a = 0; a < 16; a++) begin
         next_frame();
         bus_write({11'b0, 4'(a), 1'b1, new_val(a)});
         next_frame();
         next_frame();
         chk(rd_data == stat(4'(a), cur[a]), "R6 write returns old value", rd_data, stat(4'(a), cur[a]));
         chk({seen_addr, seen_rw, seen_data} == {4'(a), 1'b1, new_val(a)}, "R4 serial write fields",
             {11'b0, seen_addr, seen_rw, seen_data}, {11'b0, 4'(a), 1'b1, new_val(a)});
         cur[a] = new_val(a);
         next_frame();
         chk(rd_data == stat(4'(a), cur[a]), "R6 new value next frame", rd_data, stat(4'(a), cur[a]));
      end

      // R7 read sweep, codec register changed behind the block
      for (int a = 0; a < 16; a++) begin
         next_frame();
         bus_write({11'b0, 4'(a), 1'b0, 16'hFFFF});
         next_frame();
         next_frame();
         chk(rd_data == stat(4'(a), cur[a]), "R5 read returns contents", rd_data, stat(4'(a), cur[a]));
         chk({seen_addr, seen_rw, seen_data} == {4'(a), 1'b0, 16'hFFFF}, "R4 serial read fields",
             {11'b0, seen_addr, seen_rw, seen_data}, {11'b0, 4'(a), 1'b0, 16'hFFFF});
         chk(creg[a] == cur[a], "R4 read does not write", {16'b0, creg[a]}, {16'b0, cur[a]});
         cur[a] = cur[a] ^ 16'h5A5A;
         creg[a] = cur[a];
         next_frame();
         chk(rd_data == stat(4'(a), cur[a]), "R7 repeated every frame", rd_data, stat(4'(a), cur[a]));
      end

      // R2 mid-frame change does not affect the running frame
      next_frame();
      bus_write({11'b0, 4'd3, 1'b0, 16'h0});
      next_frame();
      repeat (20 * DIV) @(negedge clk);
      bus_write({11'b0, 4'd9, 1'b0, 16'h0});
      next_frame();
      chk(rd_data == stat(4'd3, cur[3]), "R2 mid-frame write ignored this frame", rd_data, stat(4'd3, cur[3]));
      next_frame();
      chk(rd_data == stat(4'd9, cur[9]), "R2 new command next frame", rd_data, stat(4'd9, cur[9]));

      // R1 upper bits ignored, returned write flag cleared
      next_frame();
      bus_write(32'hFFE0_0000 | {11'b0, 4'd12, 1'b1, 16'hBEEF});
      next_frame();
      next_frame();
      chk(rd_data[31:21] == 11'b0, "R1 upper bits read zero", rd_data, {11'b0, rd_data[20:0]});
      chk(rd_data[16] == 1'b0, "R1 write flag reads zero", rd_data, {rd_data[31:17], 1'b0, rd_data[15:0]});
      chk(seen_addr == 4'd12 && seen_rw, "R1 field layout on link", {27'b0, seen_addr, seen_rw}, {27'b0, 4'd12, 1'b1});
      chk(stray_ones == 0, "R4 zero outside fields", stray_ones, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule